// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical address once a block-translation lookup has missed. The top four bits of the address pick one of sixteen segment registers. That register supplies a 24-bit virtual segment identifier, two protection-key bits, a no-execute bit and a direct-store bit. The walker hashes the segment identifier with the page index and combines the result with the page-table base register to get the address of a group of eight two-word entries in memory. It reads those entries one word at a time over a simple request/response port and looks for a valid entry with a matching tag.

When the first group holds no usable entry, the walker searches a second group whose hash is the complement of the first. When an entry grants the access, the walker returns the physical page number joined to the page offset, along with read and write permission. It also sets the referenced bit, and the changed bit on writes, in the entry's second word, and it stores that word back only when one of those bits was clear. Faults come back as a status code. Direct-store segments never reach memory: any access to them faults.

A request is accepted with `start` while `busy` is low. The result is valid in the cycle `done` is high and holds until the next request.

Top module: `hptw_walker`

## Requirements
- R1: Bits 31:28 of the effective address select the segment register. If that register's bit 31 is set, the walk ends with no memory traffic. A code fetch (accType 1) then gets status 3, and every other access type gets status 4.
- R2: A code fetch to a segment with bit 28 set ends with status 3 and no memory reads. A data access to the same segment is translated normally.
- R3: The primary group address is (base AND 0xFFFF0000) OR (H AND M). Here H = ((VSID XOR page index) AND 0x7FFFF) << 6, VSID is segment bits 23:0, the page index is address bits 27:12, and M = (base bits 8:0 << 16) OR 0xFFC0. Entry k of a group sits at group + 8k, with its first word there and its second word at +4.
- R4: The secondary group uses H' = (NOT H) AND 0x01FFFFC0 in the same formula. It is read only after all eight primary entries have failed to grant the access.
- R5: An entry matches only if first-word bit 31 is 1, first-word bit 6 equals the pass (0 primary, 1 secondary), and the first word AND 0x7FFFFFBF equals (VSID << 7) OR (page index >> 10). The second word is read only for a matching entry.
- R6: The key is segment bit 30 when privUser=0 and segment bit 29 when privUser=1. With key 0, read is always allowed, and write is allowed unless PP (second-word bits 1:0) is 3. With key 1, PP 0 allows nothing, PP 1 or 3 allows read only, and PP 2 allows read and write. A write needs write permission and a read needs read permission.
- R7: On success (status 0), physAddr is second-word bits 31:12 followed by address bits 11:0, and permRead/permWrite give the entry's rights. `done` is a single-cycle pulse.
- R8: On success, the second word with bit 8 set (and bit 7 set for writes) is written to the entry's second-word address, and only if that changes the word.
- R9: If neither group grants the access, the status is 2 when some entry matched and 1 when none did.
- R10: The scan stops at the first entry that grants the access. Later entries and the secondary group are not read.
- R11: Each memory request carries one word and stays asserted with a stable address and direction until memReqReady. A read completes with memRspValid. No request is issued while idle.
- R12: On any fault, physAddr, permRead and permWrite are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken when not busy) |
| effAddr | input | 32 | Effective address |
| isWrite | input | 1 | 1 for a store access |
| accType | input | 3 | 0 data, 1 code, 2 float, 3 reservation, 4 external control |
| privUser | input | 1 | 1 when in user privilege |
| segRegs | input | 512 | Sixteen segment registers, register n at bits 32n+31:32n |
| tableBase | input | 32 | Page-table base and hash-mask register |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| status | output | 3 | 0 ok, 1 no match, 2 protection, 3 no-execute, 4 direct-store |
| physAddr | output | 32 | Translated address |
| permRead | output | 1 | Read allowed |
| permWrite | output | 1 | Write allowed |
| memReqValid | output | 1 | Memory request |
| memReqReady | input | 1 | Memory accepts request |
| memReqWrite | output | 1 | Request is a write |
| memAddr | output | 32 | Request byte address |
| memWData | output | 32 | Write data |
| memRspValid | input | 1 | Read data valid |
| memRData | input | 32 | Read data |

## Verification
The pair of events that most often share a cycle is the last primary entry being rejected and the switch to the secondary group. The same step must decide between advancing the slot, changing the pass, or ending with status 1 or 2. The bench provokes this by placing the only granting entry in primary slot 7 or in secondary slot 3, behind a decoy carrying the wrong pass bit. It also places a denied primary entry ahead of a granting secondary one. Each case is judged by the exact read count, the status, and the address and data of the single write-back, all against a model built from the formulas. Ready stalls are interleaved so that a held request coincides with these decisions.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_NOMATCH = 3'd1,
    ST_PROT    = 3'd2,
    ST_NOEXEC  = 3'd3,
    ST_DIRECT  = 3'd4
  } walk_status_t;

  typedef enum logic [2:0] {
    ACC_DATA   = 3'd0,
    ACC_CODE   = 3'd1,
    ACC_FLOAT  = 3'd2,
    ACC_RESV   = 3'd3,
    ACC_EXTCTL = 3'd4
  } access_t;

  typedef enum logic [3:0] {
    S_IDLE, S_SEG, S_RD0, S_WAIT0, S_MATCH, S_RD1, S_WAIT1,
    S_GRANT, S_NEXT, S_WB, S_DONE
  } walk_state_t;

  // control -> datapath
  typedef struct packed {
    logic         capture;
    logic         loadW0;
    logic         loadW1;
    logic         advance;
    logic         toSecondary;
    logic         noteMatch;
    logic         selWord1;
    logic         latchResult;
    walk_status_t resultCode;
  } walk_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic segDirect;
    logic segNoExec;
    logic isCode;
    logic entryMatch;
    logic entryGrant;
    logic lastEntry;
    logic secondPass;
    logic sawMatch;
    logic needWriteback;
  } walk_flags_t;

endpackage

// File: rtl/hptw_datapath.sv
module hptw_datapath
  import hptw_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8,
  parameter int NUM_SEGS      = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  walk_strobe_t             strobe,
  input  logic [31:0]              effAddr,
  input  logic                     isWrite,
  input  access_t                  accType,
  input  logic                     privUser,
  input  logic [NUM_SEGS*32-1:0]   segRegs,
  input  logic [31:0]              tableBase,
  input  logic [31:0]              memRData,
  output walk_flags_t              flags,
  output logic [31:0]              memAddr,
  output logic [31:0]              memWData,
  output walk_status_t             status,
  output logic [31:0]              physAddr,
  output logic                     permRead,
  output logic                     permWrite
);
  localparam int IDX_W = $clog2(GROUP_ENTRIES);
  localparam int SEL_W = $clog2(NUM_SEGS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  logic [31:0] eaQ, segQ, sdrQ, w0Q, w1Q;
  logic        wrQ, codeQ, prQ, passQ, sawMatchQ;
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ <= '0; segQ <= '0; sdrQ <= '0; w0Q <= '0; w1Q <= '0;
      wrQ <= 1'b0; codeQ <= 1'b0; prQ <= 1'b0; passQ <= 1'b0;
      sawMatchQ <= 1'b0; idxQ <= '0;
    end else begin
      if (strobe.capture) begin
        eaQ       <= effAddr;
        segQ      <= segRegs[effAddr[31 -: SEL_W]*32 +: 32];
        sdrQ      <= tableBase;
        wrQ       <= isWrite;
        codeQ     <= (accType == ACC_CODE);
        prQ       <= privUser;
        passQ     <= 1'b0;
        idxQ      <= '0;
        sawMatchQ <= 1'b0;
      end
      if (strobe.loadW0)    w0Q <= memRData;
      if (strobe.loadW1)    w1Q <= memRData;
      if (strobe.advance)   idxQ <= idxQ + 1'b1;
      if (strobe.toSecondary) begin
        passQ <= 1'b1;
        idxQ  <= '0;
      end
      if (strobe.noteMatch) sawMatchQ <= 1'b1;
    end
  end

  // hashing and group address
  logic [23:0] vsid;
  logic [15:0] pageIdx;
  logic [31:0] hashPri, hashSec, hashMask, hashSel, groupAddr, entryAddr, ptem, w1Next;
  logic        keyBit, allowRd, allowWr, grant;
  logic [1:0]  pp;

  always_comb begin
    vsid      = segQ[23:0];
    pageIdx   = eaQ[27:12];
    hashPri   = (({8'h0, vsid} ^ {16'h0, pageIdx}) & 32'h0007_FFFF) << 6;
    hashSec   = ~hashPri & 32'h01FF_FFC0;
    hashMask  = {7'h0, sdrQ[8:0], 16'hFFC0};
    hashSel   = passQ ? hashSec : hashPri;
    groupAddr = {sdrQ[31:16], 16'h0} | (hashSel & hashMask);
    entryAddr = groupAddr + (32'(idxQ) << 3);
    ptem      = {1'b0, vsid, 1'b0, pageIdx[15:10]};
  end

  // rights
  always_comb begin
    keyBit = prQ ? segQ[29] : segQ[30];
    pp     = w1Q[1:0];
    if (!keyBit) begin
      allowRd = 1'b1;
      allowWr = (pp != 2'd3);
    end else begin
      allowRd = (pp != 2'd0);
      allowWr = (pp == 2'd2);
    end
    grant  = wrQ ? allowWr : allowRd;
    w1Next = w1Q | 32'h0000_0100 | (wrQ ? 32'h0000_0080 : 32'h0);
  end

  always_comb begin
    flags.segDirect     = segQ[31];
    flags.segNoExec     = segQ[28];
    flags.isCode        = codeQ;
    flags.entryMatch    = w0Q[31] && (w0Q[6] == passQ) &&
                          ((w0Q & 32'h7FFF_FFBF) == ptem);
    flags.entryGrant    = grant;
    flags.lastEntry     = (idxQ == LAST_IDX);
    flags.secondPass    = passQ;
    flags.sawMatch      = sawMatchQ;
    flags.needWriteback = (w1Next != w1Q);
  end

  assign memAddr  = strobe.selWord1 ? entryAddr + 32'd4 : entryAddr;
  assign memWData = w1Next;

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      status    <= ST_OK;
      physAddr  <= '0;
      permRead  <= 1'b0;
      permWrite <= 1'b0;
    end else if (strobe.latchResult) begin
      status <= strobe.resultCode;
      if (strobe.resultCode == ST_OK) begin
        physAddr  <= {w1Q[31:12], eaQ[11:0]};
        permRead  <= allowRd;
        permWrite <= allowWr;
      end else begin
        physAddr  <= '0;
        permRead  <= 1'b0;
        permWrite <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hptw_control.sv
module hptw_control
  import hptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  walk_flags_t  flags,
  input  logic         memReqReady,
  input  logic         memRspValid,
  output walk_strobe_t strobe,
  output logic         memReqValid,
  output logic         memReqWrite,
  output logic         busy,
  output logic         done
);
  walk_state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strobe      = '0;
    strobe.resultCode = ST_OK;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        strobe.capture = 1'b1;
        nextState      = S_SEG;
      end
      S_SEG: begin
        if (flags.segDirect) begin
          strobe.latchResult = 1'b1;
          strobe.resultCode  = flags.isCode ? ST_NOEXEC : ST_DIRECT;
          nextState          = S_DONE;
        end else if (flags.isCode && flags.segNoExec) begin
          strobe.latchResult = 1'b1;
          strobe.resultCode  = ST_NOEXEC;
          nextState          = S_DONE;
        end else begin
          nextState = S_RD0;
        end
      end
      S_RD0: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = S_WAIT0;
      end
      S_WAIT0: if (memRspValid) begin
        strobe.loadW0 = 1'b1;
        nextState     = S_MATCH;
      end
      S_MATCH: nextState = flags.entryMatch ? S_RD1 : S_NEXT;
      S_RD1: begin
        memReqValid     = 1'b1;
        strobe.selWord1 = 1'b1;
        if (memReqReady) nextState = S_WAIT1;
      end
      S_WAIT1: if (memRspValid) begin
        strobe.loadW1 = 1'b1;
        nextState     = S_GRANT;
      end
      S_GRANT: begin
        strobe.noteMatch = 1'b1;
        strobe.selWord1  = 1'b1;
        if (flags.entryGrant) begin
          if (flags.needWriteback) begin
            nextState = S_WB;
          end else begin
            strobe.latchResult = 1'b1;
            nextState          = S_DONE;
          end
        end else begin
          nextState = S_NEXT;
        end
      end
      S_NEXT: begin
        if (!flags.lastEntry) begin
          strobe.advance = 1'b1;
          nextState      = S_RD0;
        end else if (!flags.secondPass) begin
          strobe.toSecondary = 1'b1;
          nextState          = S_RD0;
        end else begin
          strobe.latchResult = 1'b1;
          strobe.resultCode  = flags.sawMatch ? ST_PROT : ST_NOMATCH;
          nextState          = S_DONE;
        end
      end
      S_WB: begin
        memReqValid     = 1'b1;
        memReqWrite     = 1'b1;
        strobe.selWord1 = 1'b1;
        if (memReqReady) begin
          strobe.latchResult = 1'b1;
          nextState          = S_DONE;
        end
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

endmodule

// File: rtl/hptw_walker.sv
module hptw_walker
  import hptw_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8,
  parameter int NUM_SEGS      = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [31:0]            effAddr,
  input  logic                   isWrite,
  input  logic [2:0]             accType,
  input  logic                   privUser,
  input  logic [NUM_SEGS*32-1:0] segRegs,
  input  logic [31:0]            tableBase,
  output logic                   busy,
  output logic                   done,
  output logic [2:0]             status,
  output logic [31:0]            physAddr,
  output logic                   permRead,
  output logic                   permWrite,
  output logic                   memReqValid,
  input  logic                   memReqReady,
  output logic                   memReqWrite,
  output logic [31:0]            memAddr,
  output logic [31:0]            memWData,
  input  logic                   memRspValid,
  input  logic [31:0]            memRData
);
  walk_strobe_t strobe;
  walk_flags_t  flags;
  walk_status_t statusInt;

  hptw_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .flags(flags),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .strobe(strobe), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .busy(busy), .done(done)
  );

  hptw_datapath #(.GROUP_ENTRIES(GROUP_ENTRIES), .NUM_SEGS(NUM_SEGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .effAddr(effAddr), .isWrite(isWrite), .accType(access_t'(accType)),
    .privUser(privUser), .segRegs(segRegs), .tableBase(tableBase),
    .memRData(memRData), .flags(flags), .memAddr(memAddr), .memWData(memWData),
    .status(statusInt), .physAddr(physAddr), .permRead(permRead), .permWrite(permWrite)
  );

  assign status = statusInt;

endmodule

// File: rtl/hptw_walker_checker.sv
module hptw_walker_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic [2:0]  status,
  input logic [31:0] physAddr,
  input logic        permRead,
  input logic        permWrite,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic        memReqWrite,
  input logic [31:0] memAddr,
  input logic [31:0] memWData
);
  // R11: a stalled request holds address and direction
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memAddr) && $stable(memReqWrite));

  // R11: nothing on the memory port while idle
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid);

  // R8: every write-back carries the referenced bit
  assert_wb_ref_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite |-> memWData[8]);

  // R12: faults carry no rights and no address
  assert_fault_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    done && (status != 3'd0) |-> !permRead && !permWrite && (physAddr == 32'h0));

  // R6: any granted walk includes read permission
  assert_ok_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    done && (status == 3'd0) |-> permRead);

  // R7: done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: status stays within the defined codes
  assert_status_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> status <= 3'd4);
endmodule

bind hptw_walker hptw_walker_checker u_chk (.*);

// File: tb/hptw_walker_bench.sv
`timescale 1ns/1ps
module hptw_walker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] effAddr = '0;
  logic        isWrite = 1'b0;
  logic [2:0]  accType = '0;
  logic        privUser = 1'b0;
  logic [511:0] segFlat = '0;
  logic [31:0] sdrVal = 32'h0010_0000;
  logic        busy, done, permRead, permWrite;
  logic [2:0]  status;
  logic [31:0] physAddr, memAddr, memWData, memRData;
  logic        memReqValid, memReqWrite;
  logic        memReqReady = 1'b0;
  logic        memRspValid = 1'b0;

  always #2.5 clk = ~clk;

  hptw_walker u_hptw_walker (
    .clk(clk), .rstN(rstN), .start(start), .effAddr(effAddr), .isWrite(isWrite),
    .accType(accType), .privUser(privUser), .segRegs(segFlat), .tableBase(sdrVal),
    .busy(busy), .done(done), .status(status), .physAddr(physAddr),
    .permRead(permRead), .permWrite(permWrite), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqWrite(memReqWrite), .memAddr(memAddr),
    .memWData(memWData), .memRspValid(memRspValid), .memRData(memRData)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem [logic [31:0]];
  int    nReads, nWrites;
  logic [31:0] lastWAddr, lastWData;
  logic  pendRead = 1'b0;
  logic [31:0] pendAddr = '0;
  logic  stallOn = 1'b0;
  logic  stallTick = 1'b0;

  function automatic logic [31:0] rdMem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (memReqValid && memReqReady) begin
      if (memReqWrite) begin
        mem[memAddr] = memWData;
        nWrites++;
        lastWAddr = memAddr;
        lastWData = memWData;
        pendRead <= 1'b0;
      end else begin
        nReads++;
        pendRead <= 1'b1;
        pendAddr <= memAddr;
      end
    end else begin
      pendRead <= 1'b0;
    end
  end

  always @(negedge clk) begin
    stallTick   <= ~stallTick;
    memRspValid <= pendRead;
    memRData    <= pendRead ? rdMem(pendAddr) : 32'h0;
    memReqReady <= memReqValid && (!stallOn || stallTick);
  end

  // ---------------- bookkeeping ----------------
  int nChecks = 0, nFails = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFails++;
      $display("FAIL watchdog: run hung (actual cycles %0d, expected < 150000)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference from the requirements ----------------
  logic [2:0]  expStatus;
  logic [31:0] expPhys, expWbAddr, expWbData;
  logic        expRd, expWr, expWb;
  int          expReads;

  function automatic logic [31:0] groupOf(input logic [31:0] ea, input int p);
    logic [31:0] seg, vsid, pidx, h, mask;
    seg  = segFlat[ea[31:28]*32 +: 32];
    vsid = {8'h0, seg[23:0]};
    pidx = {16'h0, ea[27:12]};
    h    = ((vsid ^ pidx) & 32'h0007_FFFF) << 6;
    if (p != 0) h = ~h & 32'h01FF_FFC0;
    mask = ((sdrVal & 32'h1FF) << 16) | 32'hFFC0;
    return (sdrVal & 32'hFFFF_0000) | (h & mask);
  endfunction

  function automatic logic [31:0] tagOf(input logic [31:0] ea, input int p);
    logic [31:0] seg;
    seg = segFlat[ea[31:28]*32 +: 32];
    return 32'h8000_0000 | (32'(p) << 6) | ({8'h0, seg[23:0]} << 7) | 32'(ea[27:22]);
  endfunction

  task automatic putEntry(input logic [31:0] ea, input int p, input int slot,
                          input logic [31:0] w0, input logic [31:0] w1);
    logic [31:0] a;
    a = groupOf(ea, p) + 32'(slot * 8);
    mem[a]     = w0;
    mem[a + 4] = w1;
  endtask

  task automatic predict(input logic [31:0] ea, input bit wr, input int acc, input bit pr);
    logic [31:0] seg, base, a, w0, w1, nw, cmpv;
    bit key, seen, hit, r, w;
    seg = segFlat[ea[31:28]*32 +: 32];
    expReads = 0; expWb = 0; expPhys = 0; expRd = 0; expWr = 0;
    expWbAddr = 0; expWbData = 0;
    if (seg[31]) expStatus = (acc == 1) ? 3'd3 : 3'd4;
    else if (acc == 1 && seg[28]) expStatus = 3'd3;
    else begin
      key  = pr ? seg[29] : seg[30];
      seen = 0; hit = 0;
      for (int p = 0; p < 2 && !hit; p++) begin
        base = groupOf(ea, p);
        cmpv = tagOf(ea, 0) & 32'h7FFF_FFFF;
        for (int i = 0; i < 8 && !hit; i++) begin
          a  = base + 32'(i * 8);
          w0 = rdMem(a);
          expReads++;
          if (w0[31] && (w0[6] == p[0]) && ((w0 & 32'h7FFF_FFBF) == cmpv)) begin
            w1 = rdMem(a + 4);
            expReads++;
            seen = 1;
            r = key ? (w1[1:0] != 2'd0) : 1'b1;
            w = key ? (w1[1:0] == 2'd2) : (w1[1:0] != 2'd3);
            if (wr ? w : r) begin
              hit = 1; expRd = r; expWr = w;
              expPhys = {w1[31:12], ea[11:0]};
              nw = w1 | 32'h100 | (wr ? 32'h80 : 32'h0);
              if (nw != w1) begin expWb = 1; expWbAddr = a + 4; expWbData = nw; end
            end
          end
        end
      end
      expStatus = hit ? 3'd0 : (seen ? 3'd2 : 3'd1);
    end
  endtask

  task automatic runCase(input string tag, input logic [31:0] ea, input bit wr,
                         input int acc, input bit pr);
    predict(ea, wr, acc, pr);
    @(negedge clk);
    nReads = 0; nWrites = 0;
    effAddr = ea; isWrite = wr; accType = 3'(acc); privUser = pr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    do @(negedge clk); while (!done);
    chk(status == expStatus, tag, "status", 32'(status), 32'(expStatus));
    chk(physAddr == expPhys, "R7", "physAddr", physAddr, expPhys);
    chk({permRead, permWrite} == {expRd, expWr}, "R6", "perms",
        32'({permRead, permWrite}), 32'({expRd, expWr}));
    chk(nReads == expReads, "R10", "read count", 32'(nReads), 32'(expReads));
    chk(nWrites == int'(expWb), "R8", "write count", 32'(nWrites), 32'(expWb));
    if (expWb && nWrites == 1) begin
      chk(lastWAddr == expWbAddr, "R8", "wb addr", lastWAddr, expWbAddr);
      chk(lastWData == expWbData, "R8", "wb data", lastWData, expWbData);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] ea, w1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memReqValid, "R11", "reset idle",
        32'({busy, done, memReqValid}), 32'h0);
    chk(physAddr == 0 && !permRead && !permWrite, "R12", "reset result",
        physAddr, 32'h0);

    // R1: direct-store segment, every access type
    segFlat[5*32 +: 32] = 32'h8000_1234;
    for (int acc = 0; acc < 5; acc++) runCase("R1", 32'h5001_2345, 1'b0, acc, 1'b0);

    // R2: no-execute segment
    mem.delete();
    segFlat[6*32 +: 32] = 32'h1000_0321;
    putEntry(32'h6000_7abc, 0, 2, tagOf(32'h6000_7abc, 0), 32'h0abc_d002);
    runCase("R2", 32'h6000_7abc, 1'b0, 1, 1'b0);
    runCase("R2", 32'h6000_7abc, 1'b0, 0, 1'b0);

    // Sweep: segment key bits x privilege x PP x direction x placement
    segFlat[3*32 +: 32] = 32'h000A_5A5A;
    for (int kb = 0; kb < 4; kb++)
      for (int pr = 0; pr < 2; pr++)
        for (int pp = 0; pp < 4; pp++)
          for (int wr = 0; wr < 2; wr++)
            for (int pl = 0; pl < 3; pl++) begin
              mem.delete();
              segFlat[3*32 +: 32] = {1'b0, kb[1], kb[0], 5'b0, 24'h0A_5A5A};
              ea = 32'h3ABC_D000 | 32'(pl * 16 + pp * 4 + wr * 256 + kb);
              w1 = 32'h1234_5000 + (32'(pl) << 12) + 32'(pp);
              stallOn = pp[0] ^ wr[0];
              if (pl == 0) putEntry(ea, 0, 0, tagOf(ea, 0), w1);
              if (pl == 1) putEntry(ea, 0, 7, tagOf(ea, 0), w1 | 32'h180);
              if (pl == 2) begin
                putEntry(ea, 0, 1, tagOf(ea, 0) | 32'h40, w1);  // wrong pass bit, R5
                putEntry(ea, 1, 3, tagOf(ea, 1), w1 | 32'h100);
              end
              runCase("R6", ea, wr[0], 0, pr[0]);
            end
    stallOn = 1'b0;

    // R9: nothing present
    mem.delete();
    segFlat[3*32 +: 32] = 32'h4000_0777;
    runCase("R9", 32'h3001_1000, 1'b0, 0, 1'b0);
    // R9: match but denied (key 1, PP 0)
    putEntry(32'h3001_1000, 0, 4, tagOf(32'h3001_1000, 0), 32'h0005_5000);
    runCase("R9", 32'h3001_1000, 1'b0, 0, 1'b0);
    // R4: denied primary, granting secondary
    putEntry(32'h3001_1000, 1, 0, tagOf(32'h3001_1000, 1), 32'h0006_6002);
    runCase("R4", 32'h3001_1000, 1'b1, 0, 1'b0);
    // R5: valid bit clear and tag off by one never match
    mem.delete();
    putEntry(32'h3001_1000, 0, 0, tagOf(32'h3001_1000, 0) & 32'h7FFF_FFFF, 32'h0007_7002);
    putEntry(32'h3001_1000, 0, 1, tagOf(32'h3001_1000, 0) ^ 32'h1, 32'h0007_7002);
    runCase("R5", 32'h3001_1000, 1'b0, 0, 1'b0);

    // R10: two granting entries, first wins
    mem.delete();
    segFlat[3*32 +: 32] = 32'h0000_0999;
    putEntry(32'h3002_2010, 0, 2, tagOf(32'h3002_2010, 0), 32'h00AA_A002);
    putEntry(32'h3002_2010, 0, 5, tagOf(32'h3002_2010, 0), 32'h00BB_B002);
    runCase("R10", 32'h3002_2010, 1'b1, 0, 1'b0);

    // R3: hash mask bits in the base register widen the group index
    mem.delete();
    sdrVal = 32'h0040_0003;
    segFlat[9*32 +: 32] = 32'h0007_FFFF;
    putEntry(32'h9123_4444, 0, 6, tagOf(32'h9123_4444, 0), 32'h0CCC_C001);
    runCase("R3", 32'h9123_4444, 1'b0, 0, 1'b1);
    putEntry(32'h9876_5000, 1, 1, tagOf(32'h9876_5000, 1), 32'h0DDD_D182);
    runCase("R3", 32'h9876_5000, 1'b1, 0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule